// File: doc/BRIEF.md
# Interleaved-Channel Black-Level Offset Corrector

This block follows a 10-bit converter whose successive samples come from two alternating sampling channels, called even and odd. The two channels never sit at exactly the same dark level, so an uncorrected picture shows a column-to-column stripe. During the dark-reference interval, the block keeps one running estimate of the dark level per channel. It then subtracts from every later sample the amount by which that sample's channel sits above a selectable target. After correction, both channels rest on the same black code.

The calibration strobe is active low and marks the dark pixels. It should stay low for at least ten pixels, and longer is better because the estimate converges slowly. The blanking input is also active low and forces the output to zero. An enable input selects corrected data or raw data. Both choices use the same two-cycle pipeline, so switching between them does not shift the downstream timing.

Top module: `eo_offset_corr`

## Requirements
- R1: During reset and on the first two clock edges after reset is released, `sample_out` is 0. Both channel estimates reset to 0.
- R2: The sample present on the edge where `cal_n` is first seen low is even (channel 0). The channel assignment alternates on every clock edge. Outside that case, the first sample after reset is even.
- R3: On each edge where `cal_n` is low, only the estimate of the current sample's channel changes. The estimate is a value L with 4 fractional bits. It changes by floor((16*sample - L)/16).
- R4: On an edge where `cal_n` is high, neither estimate changes.
- R5: `target_sel` values 0, 1, 2 and 3 select a black target of 16, 32, 48 and 64 codes. The value used is the one sampled together with the sample.
- R6: When enabled, the output equals sample - (floor(L/16) - target), using the estimate L of the sample's channel as it stands when the sample leaves the first stage.
- R7: The corrected value is clamped to the range 0 to 1023.
- R8: When `corr_en` is 0 at sample time, the output equals the raw sample.
- R9: A sample appears at `sample_out` two clock edges after it is captured, whether or not correction is enabled.
- R10: A sample captured with `blank_n` low comes out as 0. Blanking does not stop the estimates from tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | 10 | Converter sample |
| cal_n | input | 1 | Dark-pixel strobe, active low |
| blank_n | input | 1 | Output blanking, active low |
| corr_en | input | 1 | 1 = corrected output, 0 = raw output |
| target_sel | input | 2 | Black target select (16/32/48/64) |
| sample_out | output | 10 | Corrected or raw sample |

## Verification
The hardest condition to reach from the ports is a calibration strobe whose falling edge arrives while the free-running channel toggle is on odd. Only then does the forced return to even change which estimate learns which channel. The stimulus places two strobe falls an odd number of cycles apart, so one of them lands on each toggle phase. It drives strongly different dark values on the two channels, so a wrong assignment mixes the estimates and shows up in the output. The clamp limits are reached by first pulling an estimate far above and then far below the target, and then presenting extreme samples.

// File: rtl/eo_pkg.sv
// Shared constants and helpers for the interleaved black-level corrector.
// Assumes two channels that alternate sample by sample.
package eo_pkg;
    localparam int NUM_CH = 2;

    // Clamp a signed value into 0 .. hi.
    function automatic int clamp_range(input int v, input int hi);
        if (v < 0)
            return 0;
        else if (v > hi)
            return hi;
        else
            return v;
    endfunction
endpackage

// File: rtl/eo_phase.sv
// Channel toggle: reports whether the sample on this edge belongs to the odd
// channel. The first sample of a dark strobe (cal_n falling) is forced even.
// Assumes cal_n is synchronous to clk.
module eo_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_n,
    output logic cur_odd
);
    logic phase_q;
    logic cal_prev_q;
    logic cal_fall;

    // Detect the strobe's falling edge and pick the parity for this sample.
    always_comb begin
        cal_fall = cal_prev_q && !cal_n;
        cur_odd  = cal_fall ? 1'b0 : phase_q;
    end

    // Advance the toggle and remember the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= 1'b0;
            cal_prev_q <= 1'b1;
        end else begin
            phase_q    <= !cur_odd;
            cal_prev_q <= cal_n;
        end
    end
endmodule

// File: rtl/eo_tracker.sv
// Per-channel dark-level estimator: a leaky average held with FRAC
// fractional bits. Each update moves the estimate by the error divided by
// 2**SHIFT, rounded toward minus infinity. Assumes upd is asserted only on
// dark samples of this channel.
module eo_tracker #(
    parameter int DW    = 10,
    parameter int FRAC  = 4,
    parameter int SHIFT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [DW-1:0]        sample,
    output logic [DW+FRAC-1:0]   level
);
    localparam int LW = DW + FRAC;

    logic signed [LW:0] err_s;
    logic signed [LW:0] step_s;
    logic signed [LW:0] nxt_s;

    // Compute the error against the scaled sample and the next estimate.
    always_comb begin
        err_s  = $signed({1'b0, sample, {FRAC{1'b0}}}) - $signed({1'b0, level});
        step_s = err_s >>> SHIFT;
        nxt_s  = $signed({1'b0, level}) + step_s;
    end

    // Hold the estimate; update it only when this channel sees a dark sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= '0;
        else if (upd)
            level <= nxt_s[LW-1:0];
    end
endmodule

// File: rtl/eo_out_stage.sv
// Second pipeline stage: subtracts the channel offset (estimate minus target),
// clamps the result, and applies the bypass and blanking choices.
// Assumes the level input is already selected for the sample's channel.
module eo_out_stage #(
    parameter int DW    = 10,
    parameter int FRAC  = 4,
    parameter int TSTEP = 16,
    parameter int SELW  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        s1_sample,
    input  logic                 s1_blank_n,
    input  logic                 s1_en,
    input  logic [SELW-1:0]      s1_sel,
    input  logic [DW+FRAC-1:0]   level,
    output logic [DW-1:0]        out_q
);
    localparam int CW  = DW + 2;
    localparam int MAXV = (1 << DW) - 1;

    logic [DW-1:0]        tgt;
    logic signed [CW-1:0] offset_s;
    logic signed [CW-1:0] corr_s;
    logic [DW-1:0]        corr_sat;

    // Form target, offset and clamped corrected value.
    always_comb begin
        tgt      = DW'((int'(s1_sel) + 1) * TSTEP);
        offset_s = $signed({2'b00, level[FRAC +: DW]}) - $signed({2'b00, tgt});
        corr_s   = $signed({2'b00, s1_sample}) - offset_s;
        corr_sat = DW'(eo_pkg::clamp_range(int'(corr_s), MAXV));
    end

    // Register the output with blanking taking precedence over bypass.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (!s1_blank_n)
            out_q <= '0;
        else if (!s1_en)
            out_q <= s1_sample;
        else
            out_q <= corr_sat;
    end
endmodule

// File: rtl/eo_offset_corr.sv
// Top of the interleaved black-level corrector. Stage 1 captures the sample
// and its controls; stage 2 corrects and registers it. Two estimators, one per
// channel, learn while cal_n is low. Assumes all inputs are synchronous to clk.
module eo_offset_corr #(
    parameter int DW    = 10,
    parameter int FRAC  = 4,
    parameter int SHIFT = 4,
    parameter int TSTEP = 16,
    parameter int SELW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   sample_in,
    input  logic            cal_n,
    input  logic            blank_n,
    input  logic            corr_en,
    input  logic [SELW-1:0] target_sel,
    output logic [DW-1:0]   sample_out
);
    localparam int LW = DW + FRAC;

    logic            cur_odd;
    logic [DW-1:0]   s1_sample;
    logic            s1_odd;
    logic            s1_blank_n;
    logic            s1_en;
    logic [SELW-1:0] s1_sel;
    logic [LW-1:0]   lvl [eo_pkg::NUM_CH];
    logic [LW-1:0]   lvl_even;
    logic [LW-1:0]   lvl_odd;
    logic [LW-1:0]   lvl_pick;

    eo_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .cal_n   (cal_n),
        .cur_odd (cur_odd)
    );

    // One estimator per channel; each learns only its own dark samples.
    for (genvar g = 0; g < eo_pkg::NUM_CH; g++) begin : g_ch
        logic upd;
        assign upd = !cal_n && (cur_odd == (g == 1));
        eo_tracker #(.DW(DW), .FRAC(FRAC), .SHIFT(SHIFT)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd),
            .sample (sample_in),
            .level  (lvl[g])
        );
    end

    // Name the two estimates and pick the one for the staged sample.
    always_comb begin
        lvl_even = lvl[0];
        lvl_odd  = lvl[1];
        lvl_pick = s1_odd ? lvl_odd : lvl_even;
    end

    // Stage 1: capture the sample with its parity and controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sample  <= '0;
            s1_odd     <= 1'b0;
            s1_blank_n <= 1'b0;
            s1_en      <= 1'b0;
            s1_sel     <= '0;
        end else begin
            s1_sample  <= sample_in;
            s1_odd     <= cur_odd;
            s1_blank_n <= blank_n;
            s1_en      <= corr_en;
            s1_sel     <= target_sel;
        end
    end

    eo_out_stage #(.DW(DW), .FRAC(FRAC), .TSTEP(TSTEP), .SELW(SELW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_sample  (s1_sample),
        .s1_blank_n (s1_blank_n),
        .s1_en      (s1_en),
        .s1_sel     (s1_sel),
        .level      (lvl_pick),
        .out_q      (sample_out)
    );
endmodule

// File: rtl/eo_offset_corr_chk.sv
// Property checker for the corrector, attached by bind. Uses an age counter
// so that no property looks back past the release of reset.
module eo_offset_corr_chk #(
    parameter int DW = 10,
    parameter int LW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] sample_in,
    input logic          cal_n,
    input logic          blank_n,
    input logic          corr_en,
    input logic [DW-1:0] sample_out,
    input logic          cur_odd,
    input logic [LW-1:0] lvl_even,
    input logic [LW-1:0] lvl_odd
);
    logic [1:0] age;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2 && !$past(blank_n, 2)) |-> sample_out == '0); // R10
    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2 && $past(blank_n, 2) && !$past(corr_en, 2)) |-> sample_out == $past(sample_in, 2)); // R8
    AST_EVEN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 1 && $fell(cal_n)) |-> !cur_odd); // R2
    AST_PARITY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 1 && !$fell(cal_n)) |-> cur_odd != $past(cur_odd)); // R2
    AST_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_n |=> ($stable(lvl_even) && $stable(lvl_odd))); // R4
    AST_EVEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_n && cur_odd) |=> $stable(lvl_even)); // R3
    AST_ODD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_n && !cur_odd) |=> $stable(lvl_odd)); // R3
endmodule

bind eo_offset_corr eo_offset_corr_chk #(.DW(DW), .LW(DW + FRAC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_in  (sample_in),
    .cal_n      (cal_n),
    .blank_n    (blank_n),
    .corr_en    (corr_en),
    .sample_out (sample_out),
    .cur_odd    (cur_odd),
    .lvl_even   (lvl_even),
    .lvl_odd    (lvl_odd)
);

// File: tb/tb_eo_offset_corr.sv
// Bench: a behavioural integer model predicts every output and is compared
// on each falling clock edge.
module tb_eo_offset_corr;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sample_in = '0;
    logic       cal_n = 1'b1;
    logic       blank_n = 1'b1;
    logic       corr_en = 1'b0;
    logic [1:0] target_sel = '0;
    logic [9:0] sample_out;

    int    errors = 0;
    int    checks = 0;
    string phase_tag = "R1";

    // Model state.
    int    m_lvl [2];
    int    m_ph = 0;
    int    m_calprev = 1;
    int    m_s1_s = 0, m_s1_odd = 0, m_s1_bl = 0, m_s1_en = 0, m_s1_sel = 0;
    string m_s1_tag = "R1";
    int    exp_out = 0;
    string exp_tag = "R1";
    bit    started = 0;

    eo_offset_corr dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (sample_in),
        .cal_n      (cal_n),
        .blank_n    (blank_n),
        .corr_en    (corr_en),
        .target_sel (target_sel),
        .sample_out (sample_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model, evaluated on every rising edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_lvl[0] = 0; m_lvl[1] = 0; m_ph = 0; m_calprev = 1;
            m_s1_s = 0; m_s1_odd = 0; m_s1_bl = 0; m_s1_en = 0; m_s1_sel = 0;
            m_s1_tag = "R1";
            exp_out = 0; exp_tag = "R1";
        end else begin
            int odd, c;
            odd = (m_calprev == 1 && cal_n == 0) ? 0 : m_ph;
            if (!m_s1_bl) begin
                exp_out = 0; exp_tag = (m_s1_tag == "R1") ? "R1" : "R10";
            end else if (!m_s1_en) begin
                exp_out = m_s1_s; exp_tag = "R8";
            end else begin
                c = m_s1_s - (m_lvl[m_s1_odd] / 16 - 16 * (m_s1_sel + 1));
                exp_tag = m_s1_tag;
                if (c < 0) begin c = 0; exp_tag = "R7"; end
                if (c > 1023) begin c = 1023; exp_tag = "R7"; end
                exp_out = c;
            end
            m_s1_s = sample_in; m_s1_odd = odd; m_s1_bl = blank_n;
            m_s1_en = corr_en; m_s1_sel = target_sel; m_s1_tag = phase_tag;
            if (!cal_n)
                m_lvl[odd] = m_lvl[odd] + ((int'(sample_in) * 16 - m_lvl[odd]) >>> 4);
            m_ph = 1 - odd;
            m_calprev = cal_n;
        end
    end

    // One cycle: compare the output, then drive the next inputs.
    task automatic step(input bit rn, input int s, input bit c, input bit b, input bit e, input int sel);
        @(negedge clk);
        if (started) begin
            checks++;
            if (int'(sample_out) !== exp_out) begin
                errors++;
                $display("FAIL %s: sample_out=%0d expected=%0d at %0t", exp_tag, sample_out, exp_out, $time);
            end
        end
        rst_n      = rn;
        sample_in  = 10'(s);
        cal_n      = c;
        blank_n    = b;
        corr_en    = e;
        target_sel = 2'(sel);
    endtask

    // Dark strobe of n samples: even gets ev, odd gets od, counted from the fall.
    task automatic dark(input int n, input int ev, input int od, input int sel);
        for (int k = 0; k < n; k++)
            step(1, (k % 2 == 0) ? ev : od, 0, 1, 1, sel);
    endtask

    initial begin
        phase_tag = "R1";
        for (int i = 0; i < 4; i++) step(0, 500, 1, 1, 1, 0);
        for (int i = 0; i < 3; i++) step(1, 700, 1, 1, 1, 0);

        phase_tag = "R8";
        for (int i = 0; i < 40; i++) step(1, (i * 37) % 1024, 1, 1, 0, 0);

        phase_tag = "R5";
        for (int i = 0; i < 40; i++) step(1, 200 + i * 7, 1, 1, 1, i % 4);

        phase_tag = "R3";
        dark(300, 100, 140, 0);

        phase_tag = "R6";
        for (int i = 0; i < 60; i++) step(1, 150 + (i % 2) * 40 + i, 1, 1, 1, i % 4);

        phase_tag = "R4";
        for (int i = 0; i < 40; i++) step(1, 1000 - i, 1, 1, 1, 1);
        for (int i = 0; i < 20; i++) step(1, 300 + i, 1, 1, 1, 0);

        phase_tag = "R2";
        step(1, 400, 1, 1, 1, 0);
        dark(40, 250, 60, 0);
        for (int i = 0; i < 5; i++) step(1, 300, 1, 1, 1, 0);
        dark(41, 250, 60, 0);
        for (int i = 0; i < 20; i++) step(1, 260 + (i % 2) * 10, 1, 1, 1, 2);

        phase_tag = "R7";
        dark(200, 900, 900, 0);
        for (int i = 0; i < 10; i++) step(1, i * 3, 1, 1, 1, 0);
        dark(400, 20, 30, 3);
        for (int i = 0; i < 10; i++) step(1, 1023 - i * 3, 1, 1, 1, 3);

        phase_tag = "R10";
        for (int i = 0; i < 30; i++) step(1, 400 + i, (i % 7) != 0, (i % 3) != 0, 1, 1);

        phase_tag = "R9";
        for (int i = 0; i < 30; i++) step(1, (i % 5 == 0) ? 800 : 100, 1, 1, i % 2, 0);

        phase_tag = "R1";
        step(0, 600, 1, 1, 1, 0);
        step(0, 600, 1, 1, 1, 0);
        for (int i = 0; i < 6; i++) step(1, 600, 1, 1, 1, 0);
        step(1, 600, 1, 1, 1, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1: watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule